// File: doc/BRIEF.md
# Cyclic Bit-Pattern Player with Line Coding

This block replays a stored bit pattern in an endless loop and shapes each bit onto one serial output line with one of three line codes. It runs from a clock at twice the bit rate, so every bit occupies two clock cycles: a first half and a second half. A single-bit write port loads the pattern store. A programmable last-address value sets how much of the store is played before the read pointer returns to address 0.

A trigger output runs beside the data. In one mode it is a square wave whose period is any whole number of bits. In the other mode it is a marker that is high while the bit from address 0 is on the line. The serial output can be forced low without stopping playback, so the data and the marker stay in step when the output is enabled again.

Top module: `pattern_playback_encoder`

## Requirements
- R1: While `rst` is high (sampled on the rising edge), `ser_out` and `trig_out` are 0 from the next cycle. After `rst` falls, playback starts at address 0 with its first half, and the pattern store keeps its contents.
- R2: With `line_fmt` = 0 (non-return-to-zero), `ser_out` holds the bit value for both halves. Each bit lasts two clock cycles, and `ser_out` lags the internal read state by one register.
- R3: With `line_fmt` = 1 (return-to-zero), `ser_out` carries the bit value in the first half and 0 in the second half.
- R4: With `line_fmt` = 2 (return-to-one), `ser_out` carries the bit value in the first half and 1 in the second half. The code `line_fmt` = 3 behaves like code 0.
- R5: The read address runs 0, 1, … up to `last_addr` and then returns to 0. A `last_addr` of 0 repeats bit 0 forever. If `last_addr` is lowered below the current address, the read address returns to 0 at the end of the current bit.
- R6: The store holds 8192 bits. Bit `wr_addr` takes `wr_data` on a rising edge when `wr_en` = 1, with no regard to reset. The bit value is fetched in the first half of each bit period, so a write made in that same cycle first shows at the next playback of that address.
- R7: While `out_en` = 0, `ser_out` is 0 one cycle later. Addressing and the trigger keep running, so playback resumes in step when `out_en` returns to 1.
- R8: With `trig_sel` = 0, `trig_out` changes level every N clock cycles (half-bits), where N = `div_n`. This gives a period of N bits at exactly 50% duty for odd N as well. A `div_n` of 0 acts as 1.
- R9: With `trig_sel` = 1, `trig_out` is high for exactly the two cycles in which `ser_out` carries the bit from address 0, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Pattern store write strobe |
| wr_addr | input | 13 | Bit address written |
| wr_data | input | 1 | Bit value written |
| last_addr | input | 13 | Final address of the loop |
| line_fmt | input | 2 | Line code: 0 NRZ, 1 RZ, 2 return-to-one, 3 as 0 |
| out_en | input | 1 | 1 drives data, 0 forces the line low |
| trig_sel | input | 1 | 0 divided clock, 1 address-0 marker |
| div_n | input | 16 | Trigger divide factor in bits |
| ser_out | output | 1 | Encoded serial data |
| trig_out | output | 1 | Trigger output |

## Verification
The hardest situation to reach is a write that lands in the very cycle its address is being fetched. Close to that is a shrink of `last_addr` while the read pointer is already past the new end. The bench reaches the first case with a long burst of writes into a short loop, so fetch cycles and write cycles collide many times. It reaches the second case by playing the full 8192-bit store until the pointer is deep in it, and then lowering `last_addr`. A behavioural model that applies each write after its read follows both cases on every clock.

// File: rtl/ppe_pkg.sv
package ppe_pkg;

    typedef enum logic [1:0] {
        LC_NRZ  = 2'd0,
        LC_RZ   = 2'd1,
        LC_RONE = 2'd2,
        LC_ALT  = 2'd3
    } line_code_e;

    // One half-bit slot presented by the sequencer to the encoder and trigger
    typedef struct packed {
        logic bit_val;
        logic second_half;
        logic at_start;
    } play_slot_t;

    function automatic logic encode_half(line_code_e code, logic b, logic second);
        logic r;
        case (code)
            LC_RZ:   r = second ? 1'b0 : b;
            LC_RONE: r = second ? 1'b1 : b;
            default: r = b;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ppe_pattern_mem.sv
module ppe_pattern_mem #(
    parameter int DEPTH_BITS = 8192,
    parameter int WORD_W     = 32
) (
    input  logic                          clk,
    input  logic                          wr_en,
    input  logic [$clog2(DEPTH_BITS)-1:0] wr_addr,
    input  logic                          wr_data,
    input  logic [$clog2(DEPTH_BITS)-1:0] rd_addr,
    output logic                          rd_bit
);
    localparam int AW    = $clog2(DEPTH_BITS);
    localparam int WORDS = DEPTH_BITS / WORD_W;
    localparam int OFF_W = $clog2(WORD_W);
    localparam int SEL_W = AW - OFF_W;

    logic [WORD_W-1:0] words [WORDS];
    logic [SEL_W-1:0]  wr_sel;
    logic [OFF_W-1:0]  wr_off;

    assign wr_sel = wr_addr[AW-1:OFF_W];
    assign wr_off = wr_addr[OFF_W-1:0];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (wr_en && (wr_sel == SEL_W'(w))) begin
                word_q[wr_off] <= wr_data;
            end
        end
        assign words[w] = word_q;
    end

    assign rd_bit = words[rd_addr[AW-1:OFF_W]][rd_addr[OFF_W-1:0]];

endmodule

// File: rtl/ppe_sequencer.sv
module ppe_sequencer
    import ppe_pkg::*;
#(
    parameter int DEPTH_BITS = 8192
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [$clog2(DEPTH_BITS)-1:0] last_addr,
    input  logic                          rd_bit,
    output logic [$clog2(DEPTH_BITS)-1:0] rd_addr,
    output play_slot_t                    slot
);
    localparam int AW = $clog2(DEPTH_BITS);

    logic          half_q;
    logic [AW-1:0] addr_q;
    logic          held_q;

    assign rd_addr          = addr_q;
    assign slot.bit_val     = half_q ? held_q : rd_bit;
    assign slot.second_half = half_q;
    assign slot.at_start    = (addr_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= 1'b0;
            addr_q <= '0;
            held_q <= 1'b0;
        end else begin
            half_q <= ~half_q;
            if (!half_q) begin
                held_q <= rd_bit;
            end else if (addr_q >= last_addr) begin
                addr_q <= '0;
            end else begin
                addr_q <= addr_q + 1'b1;
            end
        end
    end

    p_half_alt_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (half_q != $past(half_q)));

    p_addr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !half_q |=> (addr_q == $past(addr_q)));

    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (half_q && (addr_q >= last_addr)) |=> (addr_q == '0));

    p_step_r5: assert property (@(posedge clk) disable iff (rst)
        (half_q && (addr_q < last_addr)) |=> (addr_q == $past(addr_q) + 1'b1));

    p_held_r6: assert property (@(posedge clk) disable iff (rst)
        !half_q |=> (held_q == $past(rd_bit)));

endmodule

// File: rtl/ppe_line_encoder.sv
module ppe_line_encoder
    import ppe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  play_slot_t slot,
    input  logic [1:0] line_fmt,
    input  logic       out_en,
    output logic       ser_out
);
    logic       ser_q;
    line_code_e code;

    assign code    = line_code_e'(line_fmt);
    assign ser_out = ser_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_q <= 1'b0;
        end else if (!out_en) begin
            ser_q <= 1'b0;
        end else begin
            ser_q <= encode_half(code, slot.bit_val, slot.second_half);
        end
    end

    p_off_low_r7: assert property (@(posedge clk) disable iff (rst)
        !out_en |=> !ser_out);

    p_rz_low_r3: assert property (@(posedge clk) disable iff (rst)
        (code == LC_RZ && slot.second_half) |=> !ser_out);

    p_rone_high_r4: assert property (@(posedge clk) disable iff (rst)
        (code == LC_RONE && slot.second_half && out_en) |=> ser_out);

    p_first_half_r2: assert property (@(posedge clk) disable iff (rst)
        (!slot.second_half && out_en) |=> (ser_out == $past(slot.bit_val)));

endmodule

// File: rtl/ppe_trigger_gen.sv
module ppe_trigger_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_sel,
    input  logic [DIV_W-1:0] div_n,
    input  logic             at_start,
    output logic             trig_out
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] limit;
    logic             div_q;
    logic             wrap;
    logic             div_next;
    logic             trig_q;

    assign limit    = (div_n == '0) ? '0 : div_n - 1'b1;
    assign wrap     = (cnt_q >= limit);
    assign div_next = wrap ? ~div_q : div_q;
    assign trig_out = trig_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            div_q  <= 1'b0;
            trig_q <= 1'b0;
        end else begin
            cnt_q  <= wrap ? '0 : cnt_q + 1'b1;
            div_q  <= div_next;
            trig_q <= trig_sel ? at_start : div_next;
        end
    end

    p_div_flip_r8: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (div_q != $past(div_q)));

    p_div_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(div_q));

    p_mark_off_r9: assert property (@(posedge clk) disable iff (rst)
        (trig_sel && !at_start) |=> !trig_out);

    p_mark_on_r9: assert property (@(posedge clk) disable iff (rst)
        (trig_sel && at_start) |=> trig_out);

endmodule

// File: rtl/pattern_playback_encoder.sv
module pattern_playback_encoder
    import ppe_pkg::*;
#(
    parameter int DEPTH_BITS = 8192,
    parameter int WORD_W     = 32,
    parameter int DIV_W      = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [$clog2(DEPTH_BITS)-1:0] wr_addr,
    input  logic                          wr_data,
    input  logic [$clog2(DEPTH_BITS)-1:0] last_addr,
    input  logic [1:0]                    line_fmt,
    input  logic                          out_en,
    input  logic                          trig_sel,
    input  logic [DIV_W-1:0]              div_n,
    output logic                          ser_out,
    output logic                          trig_out
);
    localparam int AW = $clog2(DEPTH_BITS);

    logic [AW-1:0] rd_addr;
    logic          rd_bit;
    play_slot_t    slot;

    ppe_pattern_mem #(
        .DEPTH_BITS (DEPTH_BITS),
        .WORD_W     (WORD_W)
    ) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_bit  (rd_bit)
    );

    ppe_sequencer #(
        .DEPTH_BITS (DEPTH_BITS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .last_addr (last_addr),
        .rd_bit    (rd_bit),
        .rd_addr   (rd_addr),
        .slot      (slot)
    );

    ppe_line_encoder u_enc (
        .clk      (clk),
        .rst      (rst),
        .slot     (slot),
        .line_fmt (line_fmt),
        .out_en   (out_en),
        .ser_out  (ser_out)
    );

    ppe_trigger_gen #(
        .DIV_W (DIV_W)
    ) u_trig (
        .clk      (clk),
        .rst      (rst),
        .trig_sel (trig_sel),
        .div_n    (div_n),
        .at_start (slot.at_start),
        .trig_out (trig_out)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!ser_out && !trig_out));

endmodule

// File: tb/pattern_playback_encoder_bench.sv
module pattern_playback_encoder_bench;
    localparam int CLK_P = 10;
    localparam int DEPTH = 8192;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [12:0] wr_addr = '0;
    logic        wr_data = 1'b0;
    logic [12:0] last_addr = 13'd20;
    logic [1:0]  line_fmt = 2'd0;
    logic        out_en = 1'b1;
    logic        trig_sel = 1'b0;
    logic [15:0] div_n = 16'd3;
    logic        ser_out;
    logic        trig_out;

    always #(CLK_P/2) clk = ~clk;

    pattern_playback_encoder u_pattern_playback_encoder (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .last_addr(last_addr), .line_fmt(line_fmt), .out_en(out_en),
        .trig_sel(trig_sel), .div_n(div_n), .ser_out(ser_out), .trig_out(trig_out)
    );

    // ---------------- behavioural reference model ----------------
    bit    m_mem [DEPTH];
    int    m_half, m_addr, m_cnt, m_n;
    bit    m_held, m_div, m_bit, m_enc;
    bit    exp_ser, exp_trg;
    bit    cmp_on = 1'b0;
    int    checks = 0, errors = 0;
    string tag = "R1";
    bit    done = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            exp_ser = 0; exp_trg = 0;
            m_half = 0; m_addr = 0; m_held = 0; m_cnt = 0; m_div = 0;
        end else begin
            m_bit = (m_half == 0) ? m_mem[m_addr] : m_held;
            case (line_fmt)
                2'd1:    m_enc = (m_half == 1) ? 1'b0 : m_bit;
                2'd2:    m_enc = (m_half == 1) ? 1'b1 : m_bit;
                default: m_enc = m_bit;
            endcase
            exp_ser = out_en ? m_enc : 1'b0;
            m_n = (div_n == 0) ? 1 : int'(div_n);
            if (m_cnt >= m_n - 1) begin m_cnt = 0; m_div = !m_div; end
            else m_cnt = m_cnt + 1;
            exp_trg = trig_sel ? (m_addr == 0) : m_div;
            if (m_half == 0) m_held = m_mem[m_addr];
            else m_addr = (m_addr >= int'(last_addr)) ? 0 : m_addr + 1;
            m_half = 1 - m_half;
        end
        if (wr_en) m_mem[wr_addr] = wr_data;
    end

    task automatic check(input string what, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            check("ser_out", ser_out, exp_ser);
            check("trig_out", trig_out, exp_trg);
        end
    end

    function automatic bit pat(int i);
        return bit'((i & 1) ^ ((i >> 3) & 1) ^ ((i >> 6) & 1) ^ ((i % 5) == 0));
    endfunction

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        @(negedge clk);
        @(negedge clk);
        cmp_on = 1'b1;
        tag = "R1";
        // load the whole store during reset (R6 depth, R1 reset keeps memory)
        for (int i = 0; i < DEPTH; i++) begin
            wr_en = 1'b1; wr_addr = 13'(i); wr_data = pat(i);
            @(negedge clk);
        end
        wr_en = 1'b0;
        rst = 1'b0;
        tag = "R2"; line_fmt = 2'd0; run(120);
        tag = "R3"; line_fmt = 2'd1; run(120);
        tag = "R4"; line_fmt = 2'd2; run(120);
        tag = "R4"; line_fmt = 2'd3; run(60);
        line_fmt = 2'd1;
        tag = "R5"; last_addr = 13'd0; run(40);
        tag = "R9"; trig_sel = 1'b1; last_addr = 13'd9; run(120);
        tag = "R9"; last_addr = 13'd0; run(20);
        tag = "R5"; trig_sel = 1'b0; last_addr = 13'd8191; line_fmt = 2'd0; run(17000);
        tag = "R5"; last_addr = 13'd5; run(60);
        tag = "R8"; div_n = 16'd1; run(40);
        tag = "R8"; div_n = 16'd4; run(80);
        tag = "R8"; div_n = 16'd5; run(100);
        tag = "R8"; div_n = 16'd0; run(30);
        tag = "R7"; div_n = 16'd3; out_en = 1'b0; run(60);
        tag = "R7"; out_en = 1'b1; trig_sel = 1'b1; run(40);
        // writes while playing a short loop (R6)
        tag = "R6"; last_addr = 13'd7; line_fmt = 2'd2;
        for (int k = 0; k < 400; k++) begin
            wr_en = 1'b1; wr_addr = 13'((k * 3) % 8); wr_data = bit'((k / 3) & 1);
            @(negedge clk);
        end
        wr_en = 1'b0; run(60);
        // mid-run reset (R1)
        tag = "R1"; rst = 1'b1; run(3);
        rst = 1'b0; tag = "R2"; line_fmt = 2'd0; run(60);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog %s actual=running expected=finished", tag);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule